// File: doc/BRIEF.md
# Press Qualifier One-Shot

This block sits behind a keypad scanner that raises a level whenever any key is held. Mechanical keys chatter, so a raw level is not a usable event. The block turns that level into exactly one single-cycle pulse for each press that stays down for a full qualification window. After the pulse it locks until the key is let go. Bounces shorter than the window produce nothing, and a key held for seconds still produces one pulse.

The window is a parameter in clock cycles. Its default of 2,500,000 cycles gives 50 ms at a 50 MHz clock. Downstream logic, such as a code latch or a digit shifter, uses the pulse as its capture strobe.

Top module: `press_qualifier`

## Requirements
- R1: A synchronous active-low reset puts the block in its idle state. In the cycle after any clock edge that samples `rst_n` low, `press_pulse` is 0. This holds even when `key_held` is high during reset.
- R2: `press_pulse` is high for exactly one clock cycle per accepted press.
- R3: Counting starts from idle. When `key_held` is sampled high on HOLD_CYCLES+1 consecutive rising edges, `press_pulse` is 1 in the cycle right after the last of those edges.
- R4: If `key_held` is sampled low before that count is complete, the block returns to idle with no pulse. The next press must then last the full window again.
- R5: Once a pulse has been issued, no further pulse occurs while `key_held` stays high, however long it is held.
- R6: Sampling `key_held` low after the pulse re-arms the block, including a low sample on the edge that ends the pulse cycle. A following press of full length gives a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| key_held | input | 1 | Level from the keypad scanner, 1 while any key is down |
| press_pulse | output | 1 | One-cycle strobe for a qualified press |

## Verification
The internal state has four values, so a wrong state shows at the port in one of three ways. It may be a pulse that arrives one sample early or late. It may be a second pulse during one long hold. Or a valid press may pass with no pulse at all.

Because the output is decoded straight from the state register, a state error becomes visible at the latest by the end of the next qualification window. A timer that is not cleared, or that restarts wrongly after an aborted press, moves the pulse off the exact HOLD_CYCLES+1 sample count. A per-cycle compare against a run-length model exposes this on the first press that follows.

// File: rtl/pq_pkg.sv
// Package: shared state encoding for the press qualifier.
// Assumes: nothing beyond a two-bit state register.
package pq_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'd0,  // waiting for the key level
        PQ_TIMING = 2'd1,  // window timer running
        PQ_FIRE   = 2'd2,  // one-cycle strobe state
        PQ_LOCK   = 2'd3   // waiting for release
    } pq_state_t;

endpackage

// File: rtl/pq_hold_timer.sv
// Module: qualification window timer.
// Counts advance cycles from zero and flags the last count of the window.
// Assumes: HOLD_CYCLES >= 1; the controller clears the timer before each use.
module pq_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic expired
);

    localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] count_q;

    // Count register: reset and clear take priority, then saturating advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (advance && (count_q != LAST)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Terminal flag for the controller.
    assign expired = (count_q == LAST);

endmodule

// File: rtl/pq_ctrl.sv
// Module: press qualifier state machine.
// Moves idle -> timing -> fire -> lock and back to idle on release.
// Drives the timer controls and decodes the strobe from the state register.
// Assumes: key_held is already synchronous to clk.
module pq_ctrl
    import pq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_held,
    input  logic      expired,
    output pq_state_t state,
    output logic      timer_clear,
    output logic      timer_advance,
    output logic      press_pulse
);

    pq_state_t state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PQ_IDLE:   if (key_held) state_d = PQ_TIMING;
            PQ_TIMING: begin
                if (!key_held)    state_d = PQ_IDLE;
                else if (expired) state_d = PQ_FIRE;
            end
            PQ_FIRE:   state_d = key_held ? PQ_LOCK : PQ_IDLE;
            PQ_LOCK:   if (!key_held) state_d = PQ_IDLE;
            default:   state_d = PQ_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer held at zero in idle, running only while timing.
    assign timer_clear   = (state_q == PQ_IDLE);
    assign timer_advance = (state_q == PQ_TIMING);

    // Strobe is a plain decode of the registered state.
    assign press_pulse   = (state_q == PQ_FIRE);
    assign state         = state_q;

endmodule

// File: rtl/press_qualifier.sv
// Module: press qualifier top.
// Turns a held-key level into one pulse per press that lasts the full window.
// Assumes: key_held is synchronous to clk; HOLD_CYCLES >= 1.
module press_qualifier #(
    parameter int unsigned HOLD_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_held,
    output logic press_pulse
);

    pq_pkg::pq_state_t state;
    logic timer_clear;
    logic timer_advance;
    logic expired;

    // Window timer.
    pq_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .advance (timer_advance),
        .expired (expired)
    );

    // Sequencing controller.
    pq_ctrl ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_held      (key_held),
        .expired       (expired),
        .state         (state),
        .timer_clear   (timer_clear),
        .timer_advance (timer_advance),
        .press_pulse   (press_pulse)
    );

endmodule

// File: rtl/pq_checker.sv
// Module: property checker for the press qualifier, bound to the top.
// Keeps its own run-length count and re-arm flag from the port signals.
// Assumes: the bound instance exposes its state register as "state".
module pq_checker #(
    parameter int unsigned HOLD_CYCLES = 2_500_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_held,
    input logic              press_pulse,
    input pq_pkg::pq_state_t state
);
    import pq_pkg::*;

    logic [31:0] run_q;
    logic        armed_q;

    // Consecutive-high sample count, saturating at HOLD_CYCLES+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!key_held) begin
            run_q <= '0;
        end else if (run_q <= 32'(HOLD_CYCLES)) begin
            run_q <= run_q + 32'd1;
        end
    end

    // Re-arm flag: set by a low sample, cleared by a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (!key_held) begin
            armed_q <= 1'b1;
        end else if (press_pulse) begin
            armed_q <= 1'b0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !press_pulse);

    p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse);

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> (run_q >= 32'(HOLD_CYCLES) + 32'd1));

    p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PQ_TIMING && !key_held) |=> (state == PQ_IDLE && !press_pulse));

    p_one_per_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> armed_q);

    p_release_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PQ_LOCK && !key_held) |=> (state == PQ_IDLE));

endmodule

bind press_qualifier pq_checker #(
    .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_held    (key_held),
    .press_pulse (press_pulse),
    .state       (state)
);

// File: tb/press_qualifier_tb_top.sv
// Bench: directed corners plus seeded random run lengths.
// Every cycle is compared against a run-length reference model.
module press_qualifier_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic key_held = 1'b0;
    logic press_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int run      = 0;
    int pulses   = 0;
    bit exp_pulse = 1'b0;

    press_qualifier #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_held    (key_held),
        .press_pulse (press_pulse)
    );

    // Free-running bench clock.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: length of the current run of high samples, saturating.
    function automatic int next_run(int r, bit k, bit rn);
        if (!rn || !k) return 0;
        return (r > HOLD + 1) ? r : r + 1;
    endfunction

    // Reference: a pulse is due exactly when the run reaches HOLD+1.
    function automatic bit pulse_due(int r);
        return r == HOLD + 1;
    endfunction

    // Apply one cycle of stimulus, then compare the output after the edge.
    task automatic drive(bit k, bit rn, string tag);
        @(negedge clk);
        key_held = k;
        rst_n    = rn;
        run       = next_run(run, k, rn);
        exp_pulse = pulse_due(run);
        @(posedge clk);
        #1;
        n_checks++;
        if (press_pulse) pulses++;
        if (press_pulse !== exp_pulse) begin
            n_fail++;
            $display("FAIL %s: press_pulse=%0b expected %0b at %0t",
                     tag, press_pulse, exp_pulse, $time);
        end
    endtask

    // Hold one key level for several cycles.
    task automatic hold(bit k, int cycles, string tag);
        for (int i = 0; i < cycles; i++) drive(k, 1'b1, tag);
    endtask

    // Compare the number of pulses seen against the expected count.
    task automatic check_count(int got, int want, string tag);
        n_checks++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: pulse count=%0d expected %0d", tag, got, want);
        end
    endtask

    // Finish with the single summary line.
    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    // Main stimulus.
    initial begin
        int p0;
        void'($urandom(32'd20240611));

        // R1: reset with key released and with key held.
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, "R1");
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R1");
        // Key already held as reset lifts: full window from the first edge.
        hold(1'b1, HOLD + 1, "R1");
        hold(1'b0, 3, "R2");

        // R3: exact-length press, then R2 pulse width.
        p0 = pulses;
        hold(1'b1, HOLD + 1, "R3");
        hold(1'b0, 2, "R2");
        check_count(pulses - p0, 1, "R3");

        // R4: presses one sample short, separated by a single low.
        p0 = pulses;
        hold(1'b1, HOLD, "R4");
        hold(1'b0, 1, "R4");
        hold(1'b1, HOLD, "R4");
        hold(1'b0, 2, "R4");
        check_count(pulses - p0, 0, "R4");

        // R5: long hold yields one pulse only.
        p0 = pulses;
        hold(1'b1, 5 * HOLD, "R5");
        check_count(pulses - p0, 1, "R5");

        // R6: release then a full press re-arms.
        p0 = pulses;
        hold(1'b0, 1, "R6");
        hold(1'b1, HOLD + 1, "R6");
        // Release exactly on the edge that ends the pulse cycle.
        hold(1'b0, 1, "R6");
        hold(1'b1, HOLD + 1, "R6");
        hold(1'b0, 2, "R6");
        check_count(pulses - p0, 2, "R6");

        // R1: reset in mid-count restarts the window.
        hold(1'b1, HOLD - 2, "R1");
        drive(1'b1, 1'b0, "R1");
        hold(1'b1, HOLD + 1, "R1");
        hold(1'b0, 2, "R1");

        // Random run lengths around the window boundary.
        for (int seg = 0; seg < 400; seg++) begin
            bit lvl = 1'(seg % 2);
            int len = 1 + int'($urandom_range(2 * HOLD + 3));
            hold(lvl, len, "R3/R4/R5");
        end

        finish_run();
    end

endmodule